// File: doc/BRIEF.md
# CPU Bus Address Router with Open-Bus Latch

This block sits on the 16-bit address and 8-bit data bus of a small CPU and sends each access to one of five targets: a 2 KB work RAM, an eight-entry video register file, an audio register file, a pair of controller ports, or the cartridge space. It works out which target an access is for from the address and the strobes alone. It folds each access into the target's local address with that region's mirror mask, and it returns the selected target's read data to the CPU in the same cycle. Peripherals use their select together with the CPU's own read and write strobes and write data.

Some addresses in the I/O window have no target. A read there returns the open-bus latch, a register that holds the last byte seen on the data bus. A write there goes nowhere. The latch takes a new value on every access: the returned byte on a read and the written byte on a write. Every access is also reported on a snoop port, so cartridge logic can watch the whole bus. Writes to the video window raise a separate notification as well.

Top module: `sysbus_router`

## Requirements
- R1: An access to 0x0000–0x1FFF asserts `ramSel`, and `ramAddr` equals the CPU address ANDed with 0x07FF. The RAM therefore repeats four times.
- R2: An access to 0x2000–0x3FFF asserts `vidSel`, and `vidAddr` equals the low three address bits. The eight registers therefore repeat every 8 bytes.
- R3: A read at 0x4000–0x4013 or 0x4015 asserts `sndSel`, with `sndAddr` equal to the low five address bits. A read at 0x4016 or 0x4017 asserts `padSel`, with `padAddr` equal to address bit 0.
- R4: A write at 0x4016 asserts `padSel`. A write at 0x4017 asserts `sndSel` and not `padSel`. Writes at 0x4000–0x4013 and 0x4015 assert `sndSel`.
- R5: A read or write at 0x4020–0xFFFF asserts `cartSel`.
- R6: A read at 0x4014 or 0x4018–0x401F asserts no select and returns the open-bus latch on `cpuRdData`. A write there asserts no select.
- R7: The open-bus latch is 0x00 after reset. On each clock edge with an access, it loads the byte returned by a read or the byte written by a write. It holds its value when there is no access.
- R8: During every access, `snoopValid` is high and `snoopWrite` gives the direction. `snoopAddr` is the CPU address. `snoopData` is the returned byte for a read or the written byte for a write.
- R9: `vidWrNotify` is high exactly when a write falls in 0x2000–0x3FFF.
- R10: At most one select is high at any time. No select and no `snoopValid` is high when both strobes are low. Read data is valid combinationally in the strobe's cycle.
- R11: When `cpuRd` and `cpuWr` are both high, the access is treated as a write for decoding, snooping and latch loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuRd | input | 1 | CPU read strobe |
| cpuWr | input | 1 | CPU write strobe |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | Read data returned to the CPU |
| ramSel | output | 1 | Work RAM select |
| ramAddr | output | 11 | Mirrored RAM index |
| ramRdData | input | 8 | Work RAM read data |
| vidSel | output | 1 | Video register select |
| vidAddr | output | 3 | Video register index |
| vidRdData | input | 8 | Video register read data |
| sndSel | output | 1 | Audio register select |
| sndAddr | output | 5 | Audio register index |
| sndRdData | input | 8 | Audio read data |
| padSel | output | 1 | Controller port select |
| padAddr | output | 1 | Controller port index |
| padRdData | input | 8 | Controller read data |
| cartSel | output | 1 | Cartridge space select |
| cartRdData | input | 8 | Cartridge read data |
| vidWrNotify | output | 1 | Write into the video window, for the cartridge |
| snoopValid | output | 1 | An access is on the bus |
| snoopWrite | output | 1 | The snooped access is a write |
| snoopAddr | output | 16 | Snooped address |
| snoopData | output | 8 | Snooped data byte |

## Verification
Three kinds of address are exercised: the same RAM byte read through all four mirrors, video addresses at the low and high ends of their window, and every edge of the I/O window (0x4013/0x4014/0x4015, 0x401F/0x4020). Together these show whether a region boundary is off by one or a mirror mask is wrong. Reads and writes are sent to the same controller address so that the one asymmetric port is told apart from the others. Chains of writes and reads to unmapped addresses, with idle cycles between them, show whether the latch follows reads, follows writes and holds when the bus is idle. A cycle with both strobes high confirms that the write direction wins.

// File: rtl/sysbus_pkg.sv
`timescale 1ns/1ps
package sysbus_pkg;

  // Target codes; code k (k >= 1) maps to select bit k-1
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_RAM  = 3'd1,
    TGT_VID  = 3'd2,
    TGT_SND  = 3'd3,
    TGT_PAD  = 3'd4,
    TGT_CART = 3'd5
  } tgt_e;

  localparam int NUM_TGT = 5;

  // Region limits of the address map
  localparam logic [15:0] RAM_LAST   = 16'h1FFF;
  localparam logic [15:0] VID_LAST   = 16'h3FFF;
  localparam logic [15:0] IO_FIRST   = 16'h4000;
  localparam logic [15:0] CART_FIRST = 16'h4020;
  localparam logic [4:0]  SND_LAST_OFS = 5'h13;
  localparam logic [4:0]  DEAD_OFS     = 5'h14;
  localparam logic [4:0]  SND_STAT_OFS = 5'h15;
  localparam logic [4:0]  PAD0_OFS     = 5'h16;
  localparam logic [4:0]  PAD1_OFS     = 5'h17;

  // Strobes from control to datapath
  typedef struct packed {
    logic access;
    logic isWrite;
    tgt_e src;
  } ctl_s;

endpackage

// File: rtl/sysbus_ctrl.sv
`timescale 1ns/1ps
module sysbus_ctrl
  import sysbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RAM_AW = 11,
  parameter int VID_AW = 3,
  parameter int SND_AW = 5,
  parameter int PAD_AW = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic                cpuRd,
  input  logic                cpuWr,
  output ctl_s                ctl,
  output logic [NUM_TGT-1:0]  selVec,
  output logic [RAM_AW-1:0]   ramAddr,
  output logic [VID_AW-1:0]   vidAddr,
  output logic [SND_AW-1:0]   sndAddr,
  output logic [PAD_AW-1:0]   padAddr,
  output logic                vidWrNotify
);

  localparam int IO_OFS_W = 5;

  logic                access;
  logic                inVid;
  logic [IO_OFS_W-1:0] ioOfs;
  tgt_e                tgt;

  assign access = cpuRd | cpuWr;
  assign ioOfs  = cpuAddr[IO_OFS_W-1:0];
  assign inVid  = (cpuAddr > RAM_LAST) && (cpuAddr <= VID_LAST);

  // Region decode; write takes precedence when both strobes are high
  always_comb begin
    tgt = TGT_NONE;
    if (access) begin
      if (cpuAddr <= RAM_LAST)         tgt = TGT_RAM;
      else if (cpuAddr <= VID_LAST)    tgt = TGT_VID;
      else if (cpuAddr >= CART_FIRST)  tgt = TGT_CART;
      else if (cpuAddr >= IO_FIRST) begin
        unique case (ioOfs)
          DEAD_OFS:     tgt = TGT_NONE;
          SND_STAT_OFS: tgt = TGT_SND;
          PAD0_OFS:     tgt = TGT_PAD;
          PAD1_OFS:     tgt = cpuWr ? TGT_SND : TGT_PAD;
          default:      tgt = (ioOfs <= SND_LAST_OFS) ? TGT_SND : TGT_NONE;
        endcase
      end
    end
  end

  assign ctl.access  = access;
  assign ctl.isWrite = cpuWr;
  assign ctl.src     = tgt;

  // One select line per target code
  for (genvar gi = 0; gi < NUM_TGT; gi++) begin : g_sel
    assign selVec[gi] = (tgt == tgt_e'(gi + 1));
  end

  // Per-region mirroring by truncation
  assign ramAddr = cpuAddr[RAM_AW-1:0];
  assign vidAddr = cpuAddr[VID_AW-1:0];
  assign sndAddr = cpuAddr[SND_AW-1:0];
  assign padAddr = cpuAddr[PAD_AW-1:0];

  assign vidWrNotify = cpuWr && inVid;

  // Assertions
  p_onehot_sel_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selVec));

  p_idle_nosel_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuRd || cpuWr) |-> (selVec == '0));

  p_dead_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr == 16'h4014) |-> (selVec == '0));

  p_pad1_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr == 16'h4017) |-> (selVec[2] && !selVec[3]));

endmodule

// File: rtl/sysbus_dpath.sv
`timescale 1ns/1ps
module sysbus_dpath
  import sysbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_s              ctl,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] ramRdData,
  input  logic [DATA_W-1:0] vidRdData,
  input  logic [DATA_W-1:0] sndRdData,
  input  logic [DATA_W-1:0] padRdData,
  input  logic [DATA_W-1:0] cartRdData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [DATA_W-1:0] busData
);

  logic [DATA_W-1:0] openBus;
  logic [DATA_W-1:0] rdMux;

  // Read return path; unmapped reads fall back to the latch
  always_comb begin
    unique case (ctl.src)
      TGT_RAM:  rdMux = ramRdData;
      TGT_VID:  rdMux = vidRdData;
      TGT_SND:  rdMux = sndRdData;
      TGT_PAD:  rdMux = padRdData;
      TGT_CART: rdMux = cartRdData;
      default:  rdMux = openBus;
    endcase
  end

  assign cpuRdData = rdMux;
  assign busData   = ctl.isWrite ? cpuWrData : rdMux;

  // Open-bus latch
  always_ff @(posedge clk) begin
    if (!rstN)           openBus <= '0;
    else if (ctl.access) openBus <= busData;
  end

  // Assertions
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.access |=> $stable(openBus));

  p_latch_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.access |=> (openBus == $past(busData)));

  p_write_snoop_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.isWrite |-> (busData == cpuWrData));

endmodule

// File: rtl/sysbus_router.sv
`timescale 1ns/1ps
module sysbus_router
  import sysbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 11,
  parameter int VID_AW = 3,
  parameter int SND_AW = 5,
  parameter int PAD_AW = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              ramSel,
  output logic [RAM_AW-1:0] ramAddr,
  input  logic [DATA_W-1:0] ramRdData,
  output logic              vidSel,
  output logic [VID_AW-1:0] vidAddr,
  input  logic [DATA_W-1:0] vidRdData,
  output logic              sndSel,
  output logic [SND_AW-1:0] sndAddr,
  input  logic [DATA_W-1:0] sndRdData,
  output logic              padSel,
  output logic [PAD_AW-1:0] padAddr,
  input  logic [DATA_W-1:0] padRdData,
  output logic              cartSel,
  input  logic [DATA_W-1:0] cartRdData,
  output logic              vidWrNotify,
  output logic              snoopValid,
  output logic              snoopWrite,
  output logic [ADDR_W-1:0] snoopAddr,
  output logic [DATA_W-1:0] snoopData
);

  ctl_s               ctl;
  logic [NUM_TGT-1:0] selVec;
  logic [DATA_W-1:0]  busData;

  sysbus_ctrl #(
    .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .VID_AW(VID_AW),
    .SND_AW(SND_AW), .PAD_AW(PAD_AW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .ctl(ctl), .selVec(selVec),
    .ramAddr(ramAddr), .vidAddr(vidAddr), .sndAddr(sndAddr), .padAddr(padAddr),
    .vidWrNotify(vidWrNotify)
  );

  sysbus_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cpuWrData(cpuWrData),
    .ramRdData(ramRdData), .vidRdData(vidRdData), .sndRdData(sndRdData),
    .padRdData(padRdData), .cartRdData(cartRdData),
    .cpuRdData(cpuRdData), .busData(busData)
  );

  assign ramSel  = selVec[0];
  assign vidSel  = selVec[1];
  assign sndSel  = selVec[2];
  assign padSel  = selVec[3];
  assign cartSel = selVec[4];

  assign snoopValid = ctl.access;
  assign snoopWrite = ctl.isWrite;
  assign snoopAddr  = cpuAddr;
  assign snoopData  = busData;

  // Assertions
  p_snoop_every_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd || cpuWr) |-> (snoopValid && snoopAddr == cpuAddr));

  p_vid_notify_r9: assert property (@(posedge clk) disable iff (!rstN)
    vidWrNotify |-> (cpuWr && vidSel));

endmodule

// File: tb/sysbus_router_bench.sv
`timescale 1ns/1ps
module sysbus_router_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuRd = 1'b0;
  logic        cpuWr = 1'b0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  cpuRdData;
  logic        ramSel, vidSel, sndSel, padSel, cartSel;
  logic [10:0] ramAddr;
  logic [2:0]  vidAddr;
  logic [4:0]  sndAddr;
  logic [0:0]  padAddr;
  logic [7:0]  ramRdData, vidRdData, sndRdData, padRdData, cartRdData;
  logic        vidWrNotify, snoopValid, snoopWrite;
  logic [15:0] snoopAddr;
  logic [7:0]  snoopData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sysbus_router u_sysbus_router (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .ramSel(ramSel), .ramAddr(ramAddr), .ramRdData(ramRdData),
    .vidSel(vidSel), .vidAddr(vidAddr), .vidRdData(vidRdData),
    .sndSel(sndSel), .sndAddr(sndAddr), .sndRdData(sndRdData),
    .padSel(padSel), .padAddr(padAddr), .padRdData(padRdData),
    .cartSel(cartSel), .cartRdData(cartRdData),
    .vidWrNotify(vidWrNotify), .snoopValid(snoopValid), .snoopWrite(snoopWrite),
    .snoopAddr(snoopAddr), .snoopData(snoopData)
  );

  // Peripheral responders
  logic [7:0] respRam [0:2047];
  always @(posedge clk) if (ramSel && cpuWr) respRam[ramAddr] <= cpuWrData;
  assign ramRdData  = respRam[ramAddr];
  assign vidRdData  = 8'hA0 | {5'b0, vidAddr};
  assign sndRdData  = 8'h50 ^ {3'b0, sndAddr};
  assign padRdData  = 8'hC0 | {7'b0, padAddr};
  assign cartRdData = cpuAddr[15:8] ^ cpuAddr[7:0];

  // Reference model state
  logic [7:0] refRam [0:2047];
  logic [7:0] refOpen = 8'h00;

  // 0 none, 1 ram, 2 video, 3 audio, 4 pad, 5 cartridge
  function automatic int expTarget(input logic [15:0] a, input logic w);
    if (a < 16'h2000) return 1;
    if (a < 16'h4000) return 2;
    if (a > 16'h401F) return 5;
    if (a == 16'h4014 || a > 16'h4017) return 0;
    if (a == 16'h4016) return 4;
    if (a == 16'h4017) return w ? 3 : 4;
    return 3;
  endfunction

  function automatic logic [7:0] expRead(input logic [15:0] a, input int t);
    case (t)
      1: return refRam[a & 16'h07FF];
      2: return 8'hA0 | (a[7:0] & 8'h07);
      3: return 8'h50 ^ (a[7:0] & 8'h1F);
      4: return 8'hC0 | (a[7:0] & 8'h01);
      5: return a[15:8] ^ a[7:0];
      default: return refOpen;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at time %0t", req, act, exp, $time);
    end
  endtask

  task automatic access(input logic rd, input logic wr, input logic [15:0] a, input logic [7:0] d);
    int t;
    logic [4:0] expSel;
    logic [7:0] expData;
    @(negedge clk);
    cpuRd = rd; cpuWr = wr; cpuAddr = a; cpuWrData = d;
    #1;
    t = expTarget(a, wr);
    expSel = (t == 0) ? 5'b0 : 5'(1 << (t - 1));
    expData = wr ? d : expRead(a, t);
    chk({cartSel, padSel, sndSel, vidSel, ramSel} == expSel, "R1-select R3 R4 R5 R6 R11",
        {27'b0, cartSel, padSel, sndSel, vidSel, ramSel}, {27'b0, expSel});
    if (t == 1) chk(ramAddr == a[10:0], "R1 mirror", {21'b0, ramAddr}, {21'b0, a[10:0]});
    if (t == 2) chk(vidAddr == a[2:0], "R2 mirror", {29'b0, vidAddr}, {29'b0, a[2:0]});
    if (t == 3) chk(sndAddr == a[4:0], "R3 audio index", {27'b0, sndAddr}, {27'b0, a[4:0]});
    if (rd && !wr) chk(cpuRdData == expData, "R6 R10 read data", {24'b0, cpuRdData}, {24'b0, expData});
    chk(snoopValid && snoopWrite == wr && snoopAddr == a && snoopData == expData, "R8 snoop",
        {7'b0, snoopValid, snoopWrite, snoopAddr, snoopData}, {7'b0, 1'b1, wr, a, expData});
    chk(vidWrNotify == (wr && t == 2), "R9 notify", {31'b0, vidWrNotify}, {31'b0, wr && t == 2});
    @(posedge clk);
    #1;
    if (wr && t == 1) refRam[a & 16'h07FF] = d;
    refOpen = expData;
    cpuRd = 1'b0; cpuWr = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [15:0] a;
    logic [7:0]  d;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 16'h0005, 8'h15}, '{1'b0, 16'h0005, 8'h00}, '{1'b0, 16'h0805, 8'h00},
    '{1'b0, 16'h1005, 8'h00}, '{1'b0, 16'h1805, 8'h00}, '{1'b1, 16'h1FFF, 8'h7E},
    '{1'b0, 16'h07FF, 8'h00}, '{1'b0, 16'h2002, 8'h00}, '{1'b0, 16'h3FFF, 8'h00},
    '{1'b1, 16'h2345, 8'h11}, '{1'b0, 16'h4000, 8'h00}, '{1'b0, 16'h4013, 8'h00},
    '{1'b0, 16'h4015, 8'h00}, '{1'b0, 16'h4016, 8'h00}, '{1'b0, 16'h4017, 8'h00},
    '{1'b1, 16'h4016, 8'h01}, '{1'b1, 16'h4017, 8'h40}, '{1'b1, 16'h4013, 8'h0F},
    '{1'b1, 16'h4014, 8'h99}, '{1'b0, 16'h4014, 8'h00}, '{1'b0, 16'h4018, 8'h00},
    '{1'b1, 16'h401F, 8'h3C}, '{1'b0, 16'h401A, 8'h00}, '{1'b0, 16'h4020, 8'h00},
    '{1'b0, 16'hFFFF, 8'h00}, '{1'b1, 16'h8000, 8'h42}, '{1'b0, 16'h4014, 8'h00},
    '{1'b0, 16'h401F, 8'h00}
  };

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // Reset state: idle bus
    chk({cartSel, padSel, sndSel, vidSel, ramSel} == 5'b0 && !snoopValid, "R10 idle",
        {26'b0, snoopValid, cartSel, padSel, sndSel, vidSel, ramSel}, 32'h0);
    rstN = 1'b1;
    // R7: latch is 0x00 after reset
    access(1'b1, 1'b0, 16'h4014, 8'h00);
    chk(refOpen == 8'h00, "R7 reset latch", {24'b0, refOpen}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(!VECS[i].wr, VECS[i].wr, VECS[i].a, VECS[i].d);
    end

    // R7: latch holds across idle cycles
    access(1'b1, 1'b1, 16'h0000, 8'h5A);
    repeat (4) @(posedge clk);
    #1;
    chk(!snoopValid, "R10 idle snoop", {31'b0, snoopValid}, 32'h0);
    access(1'b1, 1'b0, 16'h4019, 8'h00);
    chk(refOpen == 8'h5A, "R7 hold", {24'b0, refOpen}, 32'h5A);
    // R11: both strobes at the asymmetric port act as a write
    access(1'b1, 1'b1, 16'h4017, 8'hA5);
    access(1'b1, 1'b0, 16'h4014, 8'h00);
    access(1'b1, 1'b0, 16'h0800, 8'h00);
    // R6 unmapped write has no effect on a target
    access(1'b1, 1'b1, 16'h401C, 8'h77);
    access(1'b1, 1'b0, 16'h1000, 8'h00);

    finishRun();
  end

endmodule